// File: doc/BRIEF.md
# Inter-Processor Command Mailbox

This block lets a host processor pass the physical address of a command structure to an I/O processor and get a reply address back. Each processor has its own simple register port with address, write enable, write data and read data. Three 32-bit words are reachable from both ports: a request pointer, a shared flag word and a reply pointer.

The host loads the request pointer and then rings a doorbell by setting flag bit 0. This raises `irq_to_iop`. The I/O processor acknowledges by writing 1 to bit 0. When the work is done, it loads the reply pointer and writes 0x14 to the flag word, which raises bits 2 and 4 and drives `irq_to_host`. The host clears those bits by writing 1 to them.

Each flag bit is a two-state machine with the states IDLE and RAISED. The RAISE transition fires on a write of 1 from the side that owns the setting of that bit. The DROP transition fires on a write of 1 from the other side, but only when no RAISE is requested in the same cycle. A state that sees neither event HOLDs.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all three words read zero on both ports, and `irq_to_iop` and `irq_to_host` are low.
- R2: The request pointer sits at word offset 0x0. Only host writes change it, and writes from the I/O port to that offset are ignored. Bits 1:0 always read 0. Both ports can read it.
- R3: The reply pointer sits at word offset 0x8. Only I/O-side writes change it, and host writes to that offset are ignored. Bits 1:0 always read 0. Both ports can read it.
- R4: At offset 0x4, a host write with data bit 0 = 1 moves flag bit 0 to RAISED, and an I/O write with data bit 0 = 1 moves it to IDLE. `irq_to_iop` is high exactly while bit 0 is RAISED, from the clock edge that takes the write. An I/O write cannot set bit 0, and a host write cannot clear it.
- R5: At offset 0x4, an I/O write sets flag bit 2 and/or bit 4, one for each data bit that is 1. A host write clears them the same way. `irq_to_host` is high while at least one of bits 2 and 4 is set. A host write cannot set these bits, and an I/O write cannot clear them.
- R6: When both ports write the flag word in the same cycle, the two updates are merged. If the same bit is both set and cleared in that cycle, the set wins.
- R7: Flag bits other than 0, 2 and 4 always read 0, and writes to them are ignored.
- R8: Only address bits [DECODE_W-1:0] are decoded, so the register window repeats every 2^DECODE_W bytes. Address bits 1:0 are ignored. Word slots 3 and above read 0, and writes to them have no effect.
- R9: Read data depends combinationally on the current address, with no read latency. A write becomes visible on the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | ADDR_W | Host byte address |
| h_we | input | 1 | Host write enable |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data |
| i_addr | input | ADDR_W | I/O processor byte address |
| i_we | input | 1 | I/O processor write enable |
| i_wdata | input | DATA_W | I/O processor write data |
| i_rdata | output | DATA_W | I/O processor read data |
| irq_to_iop | output | 1 | Request-ready interrupt to the I/O processor |
| irq_to_host | output | 1 | Reply-ready interrupt to the host |

## Verification
The bench builds the block with ADDR_W = 8 and DECODE_W = 6. The whole 256-byte address space is therefore four mirrors of a 16-slot window. This lets every address be written from each port and then read back through a different mirror, with the unmapped slots covered by the same sweep. The flag word is then driven through all 512 combinations of starting state, host set/clear bits and I/O set/clear bits, all written in the same cycle and padded with ones in the unused bit positions. Every outcome is compared with an arithmetic model of the merge rules.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        SEL_REQ  = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_REP  = 2'd2,
        SEL_NONE = 2'd3
    } mbx_sel_e;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    localparam int unsigned NUM_FLAGS = 3;

    // bit position in the flag word of flag cell idx
    function automatic int unsigned flag_pos(input int unsigned idx);
        return (idx == 0) ? 0 : ((idx == 1) ? 2 : 4);
    endfunction

    // flag cell idx is raised by the host (else by the I/O side)
    function automatic bit flag_host_raises(input int unsigned idx);
        return idx == 0;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DECODE_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output mbx_sel_e          sel
);
    localparam int unsigned SLOT_W = DECODE_W - 2;

    logic [SLOT_W-1:0] slot;
    logic              unused_bits;

    assign slot        = addr[DECODE_W-1:2];
    assign unused_bits = ^{addr[ADDR_W-1:DECODE_W], addr[1:0]};

    always_comb begin
        unique case (slot)
            SLOT_W'(0): sel = SEL_REQ;
            SLOT_W'(1): sel = SEL_FLAG;
            SLOT_W'(2): sel = SEL_REP;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic drop,
    output logic raised
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (raise)          state_d = FLAG_RAISED;
            FLAG_RAISED: if (drop && !raise) state_d = FLAG_IDLE;
            default:                         state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLAG_RAISED: raised = 1'b1;
            default:     raised = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbx_ptr_reg.sv
module mbx_ptr_reg #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int unsigned KEEP_W = DATA_W - ALIGN_BITS;

    logic [KEEP_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hi_q <= '0;
        else if (wr) hi_q <= wdata[DATA_W-1:ALIGN_BITS];
    end

    generate
        if (ALIGN_BITS > 0) begin : g_align
            logic unused_lo;
            assign unused_lo = ^wdata[ALIGN_BITS-1:0];
            assign q = {hi_q, {ALIGN_BITS{1'b0}}};
        end else begin : g_plain
            assign q = hi_q;
        end
    endgenerate
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DECODE_W = 10,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_we,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic              i_we,
    input  logic [DATA_W-1:0] i_wdata,
    output logic [DATA_W-1:0] i_rdata,
    output logic              irq_to_iop,
    output logic              irq_to_host
);
    mbx_sel_e          h_sel, i_sel;
    logic              h_flag_wr, i_flag_wr;
    logic [DATA_W-1:0] req_ptr_q, rep_ptr_q, flag_word;
    logic [NUM_FLAGS-1:0] flag_raised;

    mbx_decode #(.ADDR_W(ADDR_W), .DECODE_W(DECODE_W)) u_h_dec (.addr(h_addr), .sel(h_sel));
    mbx_decode #(.ADDR_W(ADDR_W), .DECODE_W(DECODE_W)) u_i_dec (.addr(i_addr), .sel(i_sel));

    assign h_flag_wr = h_we && (h_sel == SEL_FLAG);
    assign i_flag_wr = i_we && (i_sel == SEL_FLAG);

    mbx_ptr_reg #(.DATA_W(DATA_W), .ALIGN_BITS(2)) u_req_ptr (
        .clk(clk), .rst_n(rst_n),
        .wr(h_we && (h_sel == SEL_REQ)), .wdata(h_wdata), .q(req_ptr_q)
    );

    mbx_ptr_reg #(.DATA_W(DATA_W), .ALIGN_BITS(2)) u_rep_ptr (
        .clk(clk), .rst_n(rst_n),
        .wr(i_we && (i_sel == SEL_REP)), .wdata(i_wdata), .q(rep_ptr_q)
    );

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            localparam int unsigned POS = flag_pos(g);
            logic raise_req, drop_req;
            if (flag_host_raises(g)) begin : g_host_owned
                assign raise_req = h_flag_wr && h_wdata[POS];
                assign drop_req  = i_flag_wr && i_wdata[POS];
            end else begin : g_iop_owned
                assign raise_req = i_flag_wr && i_wdata[POS];
                assign drop_req  = h_flag_wr && h_wdata[POS];
            end
            mbx_flag_cell u_cell (
                .clk(clk), .rst_n(rst_n),
                .raise(raise_req), .drop(drop_req), .raised(flag_raised[g])
            );
        end
    endgenerate

    always_comb begin
        flag_word = '0;
        for (int unsigned k = 0; k < NUM_FLAGS; k++) begin
            flag_word[flag_pos(k)] = flag_raised[k];
        end
    end

    function automatic logic [DATA_W-1:0] read_mux(input mbx_sel_e s);
        unique case (s)
            SEL_REQ:  return req_ptr_q;
            SEL_FLAG: return flag_word;
            SEL_REP:  return rep_ptr_q;
            default:  return '0;
        endcase
    endfunction

    assign h_rdata     = read_mux(h_sel);
    assign i_rdata     = read_mux(i_sel);
    assign irq_to_iop  = flag_raised[0];
    assign irq_to_host = |flag_raised[NUM_FLAGS-1:1];
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DECODE_W = 10,
    parameter int unsigned DATA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] h_addr,
    input logic              h_we,
    input logic [DATA_W-1:0] h_wdata,
    input logic [ADDR_W-1:0] i_addr,
    input logic              i_we,
    input logic [DATA_W-1:0] i_wdata,
    input logic              irq_to_iop,
    input logic              irq_to_host,
    input logic [DATA_W-1:0] req_ptr_q,
    input logic [DATA_W-1:0] rep_ptr_q
);
    localparam int unsigned SLOT_W = DECODE_W - 2;

    logic h_slot_flag, i_slot_flag, h_slot_req, i_slot_rep;
    assign h_slot_flag = h_we && (h_addr[DECODE_W-1:2] == SLOT_W'(1));
    assign i_slot_flag = i_we && (i_addr[DECODE_W-1:2] == SLOT_W'(1));
    assign h_slot_req  = h_we && (h_addr[DECODE_W-1:2] == SLOT_W'(0));
    assign i_slot_rep  = i_we && (i_addr[DECODE_W-1:2] == SLOT_W'(2));

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!irq_to_iop && !irq_to_host && req_ptr_q == '0 && rep_ptr_q == '0);
        end
    end

    p_req_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_to_iop) |-> $past(h_slot_flag && h_wdata[0]));

    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_to_iop) |-> $past(i_slot_flag && i_wdata[0]));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_slot_flag && h_wdata[0]) |=> irq_to_iop);

    p_rep_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_to_host) |-> $past(i_slot_flag && (i_wdata[2] || i_wdata[4])));

    p_rep_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_to_host) |-> $past(h_slot_flag && (h_wdata[2] || h_wdata[4])));

    p_reqptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !h_slot_req |=> $stable(req_ptr_q));

    p_repptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !i_slot_rep |=> $stable(rep_ptr_q));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .ADDR_W(ADDR_W), .DECODE_W(DECODE_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata),
    .i_addr(i_addr), .i_we(i_we), .i_wdata(i_wdata),
    .irq_to_iop(irq_to_iop), .irq_to_host(irq_to_host),
    .req_ptr_q(req_ptr_q), .rep_ptr_q(rep_ptr_q)
);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] h_addr = '0, i_addr = '0;
    logic          h_we = 1'b0, i_we = 1'b0;
    logic [31:0]   h_wdata = '0, i_wdata = '0;
    logic [31:0]   h_rdata, i_rdata;
    logic          irq_to_iop, irq_to_host;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_req = '0, m_rep = '0, m_flag = '0;

    always #2.5 clk = ~clk;

    ipc_mailbox #(.ADDR_W(AW), .DECODE_W(DW), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .i_addr(i_addr), .i_we(i_we), .i_wdata(i_wdata), .i_rdata(i_rdata),
        .irq_to_iop(irq_to_iop), .irq_to_host(irq_to_host)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
        case (a[DW-1:2])
            4'd0:    return m_req;
            4'd1:    return m_flag;
            4'd2:    return m_rep;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] spread(input logic [2:0] b);
        return {27'h0, b[2], 1'b0, b[1], 1'b0, b[0]};
    endfunction

    // one clock cycle on both ports, model advanced by the rules R2..R8
    task automatic cyc(input logic hwe, input logic [AW-1:0] ha, input logic [31:0] hd,
                       input logic iwe, input logic [AW-1:0] ia, input logic [31:0] id);
        logic [3:0] hs, is;
        logic f0, f2, f4;
        @(negedge clk);
        h_we = hwe; h_addr = ha; h_wdata = hd;
        i_we = iwe; i_addr = ia; i_wdata = id;
        hs = hwe ? ha[DW-1:2] : 4'hF;
        is = iwe ? ia[DW-1:2] : 4'hF;
        @(posedge clk);
        #1;
        if (hs == 4'd0) m_req = hd & ~32'h3;
        if (is == 4'd2) m_rep = id & ~32'h3;
        f0 = (hs == 4'd1 && hd[0]) || (m_flag[0] && !(is == 4'd1 && id[0]));
        f2 = (is == 4'd1 && id[2]) || (m_flag[2] && !(hs == 4'd1 && hd[2]));
        f4 = (is == 4'd1 && id[4]) || (m_flag[4] && !(hs == 4'd1 && hd[4]));
        m_flag = spread({f4, f2, f0});
        h_we = 1'b0; i_we = 1'b0;
    endtask

    // reads through mirror k on host, mirror ~k on I/O side (R8, R9)
    task automatic verify(input logic [1:0] k);
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            h_addr = {k, 4'(w), 2'b00};
            i_addr = {~k, 4'(w), 2'b11};
            #1;
            case (w)
                0: begin chk("R2/R8", h_rdata, m_req);  chk("R2/R9", i_rdata, m_req);  end
                1: begin chk("R7/R8", h_rdata, m_flag); chk("R7/R9", i_rdata, m_flag); end
                default: begin chk("R3/R8", h_rdata, m_rep); chk("R3/R9", i_rdata, m_rep); end
            endcase
        end
        chk("R4", {31'h0, irq_to_iop}, {31'h0, m_flag[0]});
        chk("R5", {31'h0, irq_to_host}, {31'h0, m_flag[2] | m_flag[4]});
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset values
        verify(2'd0);
        chk("R1", {30'h0, irq_to_iop, irq_to_host}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2, R3, R4, R5, R7, R8: every address written from each port
        for (int a = 0; a < 256; a++) begin
            logic [31:0] d;
            d = {8'(a), ~8'(a), 8'(a) ^ 8'h5A, 8'(a * 7)};
            cyc(1'b1, AW'(a), d, 1'b0, '0, '0);
            verify(2'(a >> 6) + 2'd1);
            cyc(1'b0, '0, '0, 1'b1, AW'(a), ~d);
            verify(2'(a >> 6) + 2'd2);
        end

        // R8: whole space read, unmapped slots return zero
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            h_addr = AW'(a); i_addr = AW'(255 - a);
            #1;
            chk("R8", h_rdata, exp_rd(AW'(a)));
            chk("R8", i_rdata, exp_rd(AW'(255 - a)));
        end

        // R2, R3: same-cycle pointer writes, wrong-side writes ignored
        cyc(1'b1, 8'h00, 32'hDEADBEEF, 1'b1, 8'h40, 32'h12345677);
        verify(2'd3);
        cyc(1'b1, 8'h88, 32'hCAFEF00D, 1'b1, 8'hC8, 32'h0BADF00F);
        verify(2'd1);

        // R6: all start states x host bits x I/O bits, same cycle
        for (int s = 0; s < 8; s++) begin
            for (int hb = 0; hb < 8; hb++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    cyc(1'b1, 8'h04, 32'h14, 1'b1, 8'h44, 32'h1);
                    cyc(1'b1, 8'h84, {31'h0, s[0]}, 1'b1, 8'hC4, spread({s[2], s[1], 1'b0}));
                    cyc(1'b1, 8'h04, 32'hFFFFFFEA | spread(3'(hb)),
                        1'b1, 8'h84, 32'hFFFFFFEA | spread(3'(ib)));
                    @(negedge clk);
                    h_addr = 8'h44; i_addr = 8'hC4;
                    #1;
                    chk("R6", h_rdata, m_flag);
                    chk("R6", i_rdata, m_flag);
                    chk("R6", {30'h0, irq_to_iop, irq_to_host},
                        {30'h0, m_flag[0], m_flag[2] | m_flag[4]});
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule